// File: doc/BRIEF.md
# Board Expansion Interrupt Aggregator

This block gathers sixteen peripheral interrupt request lines into one level interrupt for the host processor. Each request line is brought into the block clock domain and watched for rising edges. A rising edge records the line as pending in a status register. Pending lines are recorded whether or not they are enabled. The host acknowledges a line by writing a one to its status bit.

Line enables live in a mask register. The mask has no plain write. The host enables lines by writing ones to a set address and disables them by writing ones to a clear address. A read of the set address returns the mask. A separate read-only register shows the synchronised live level of every input. The host output is high while any line is both pending and enabled.

The register port is a simple synchronous one. Writes are strobed by `wr_en` and take effect at the next clock edge. Read data is a combinational function of the address.

Top module: `irqagg_top`

## Requirements
- R1: After synchronous reset (`rst_n` low at a clock edge), the status register and the enable mask read 0x0000 and `irq_out` is low.
- R2: A rising edge on an input, seen after the two-flop synchroniser, sets that line's status bit. This happens whatever the mask holds. An input held high sets the bit only once, so a cleared bit stays clear until the input falls and rises again. The status bit is readable on the third clock edge after the input changes.
- R3: A write to offset 0x16 clears each status bit written as 1. Bits written as 0 are unchanged. A read of 0x16 returns the status register.
- R4: A write to offset 0x1A sets each mask bit written as 1 and leaves the other mask bits unchanged. A read of 0x1A returns the mask.
- R5: A write to offset 0x1C clears each mask bit written as 1 and leaves the other mask bits unchanged.
- R6: `irq_out` is high exactly while the bitwise AND of status and mask is non-zero. It is a function of registers only, so it can fall only after a write.
- R7: A read of offset 0x18 returns the synchronised live input levels, two clock edges after the inputs change. Writes to 0x18 are ignored.
- R8: If a rising edge and a write-one-to-clear reach the same status bit at the same clock edge, the bit ends set.
- R9: A read at any offset other than 0x16, 0x18 or 0x1A returns 0x0000. This includes 0x1C. A write to any offset other than 0x16, 0x1A or 0x1C changes nothing. Reads change no state.
- R10: Writing 0xFFFF to 0x1C and then 0xFFFF to 0x16, with no new input edges, leaves mask 0x0000, status 0x0000 and `irq_out` low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Synchronous reset, active low |
| src_in | input | 16 | Peripheral interrupt request lines, asynchronous, active high |
| wr_en | input | 1 | Register write strobe |
| addr | input | 8 | Register byte offset |
| wdata | input | 16 | Write data |
| rdata | output | 16 | Read data for `addr` |
| irq_out | output | 1 | Combined interrupt to the host, active-high level |

## Verification
The bench lines up a rising edge and an acknowledge of the same bit at one clock edge. A design that lets the clear win would lose that interrupt. The bench also acknowledges a line whose input stays high. A level-latching design would set the bit again at once and keep the host interrupted.

It writes zero bits to the set, clear and status addresses. A design that loads the mask or status directly, instead of using ones as a per-bit command, would wipe the bits that were already set.

Other checks:
- A line that goes pending while disabled must interrupt the host as soon as it is enabled.
- Writes and reads at unmapped offsets, and reads of the clear address, must leave state untouched and return zero.

// File: rtl/irqagg_pkg.sv
// Shared constants for the interrupt aggregator: register width, address
// width and the byte offsets of the mapped registers.
package irqagg_pkg;
    localparam int unsigned REG_W  = 16;
    localparam int unsigned ADDR_W = 8;
    localparam logic [ADDR_W-1:0] OFS_PEND = 8'h16;
    localparam logic [ADDR_W-1:0] OFS_LIVE = 8'h18;
    localparam logic [ADDR_W-1:0] OFS_MSET = 8'h1A;
    localparam logic [ADDR_W-1:0] OFS_MCLR = 8'h1C;
endpackage

// File: rtl/irqagg_sync.sv
// Two-flop synchroniser, one chain per request line.
// Assumes the inputs are asynchronous levels that stay stable for more than
// one clock period. Output latency is two clock edges.
module irqagg_sync #(
    parameter int unsigned W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] async_i,
    output logic [W-1:0] sync_o
);
    logic [W-1:0] meta_q;
    logic [W-1:0] sync_q;

    // Move the raw levels through two flops per line.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            meta_q <= '0;
            sync_q <= '0;
        end else begin
            meta_q <= async_i;
            sync_q <= meta_q;
        end
    end

    assign sync_o = sync_q;
endmodule

// File: rtl/irqagg_latch.sv
// Rising-edge detector and pending-status register.
// Assumes level_i is already synchronous. An edge sets its bit and wins over
// a write-one-to-clear of the same bit at the same clock edge.
module irqagg_latch #(
    parameter int unsigned W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] level_i,
    input  logic [W-1:0] clr_i,
    output logic [W-1:0] pend_o
);
    logic [W-1:0] prev_q;
    logic [W-1:0] pend_q;
    logic [W-1:0] rise;

    assign rise = level_i & ~prev_q;

    // Remember last cycle's level for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) prev_q <= '0;
        else        prev_q <= level_i;
    end

    // Update every pending bit; a set has priority over a clear.
    for (genvar i = 0; i < W; i++) begin : g_bit
        always_ff @(posedge clk) begin
            if (!rst_n)       pend_q[i] <= 1'b0;
            else if (rise[i]) pend_q[i] <= 1'b1;
            else if (clr_i[i]) pend_q[i] <= 1'b0;
        end
    end

    assign pend_o = pend_q;

    // R8
    edge_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rise != '0) |=> ((pend_q & $past(rise)) == $past(rise)));

    // R3
    clear_only_by_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((~pend_q & $past(pend_q) & ~$past(clr_i)) == '0));
endmodule

// File: rtl/irqagg_mask.sv
// Enable mask with write-one-to-set and write-one-to-clear access.
// Assumes set_i and clr_i come from different addresses. If both hit the same
// bit at one edge, the clear wins.
module irqagg_mask #(
    parameter int unsigned W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] set_i,
    input  logic [W-1:0] clr_i,
    output logic [W-1:0] mask_o
);
    logic [W-1:0] mask_q;

    // Apply the set and clear commands bit by bit.
    always_ff @(posedge clk) begin
        if (!rst_n) mask_q <= '0;
        else        mask_q <= (mask_q | set_i) & ~clr_i;
    end

    assign mask_o = mask_q;

    // R4
    mask_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((mask_q & ~$past(mask_q) & ~$past(set_i)) == '0));

    // R5
    mask_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((~mask_q & $past(mask_q) & ~$past(clr_i)) == '0));
endmodule

// File: rtl/irqagg_top.sv
// Interrupt aggregator top: register decode, read mux and combined output.
// Assumes a simple synchronous port: a write takes effect at the clock edge
// where wr_en is high, and rdata follows addr combinationally.
module irqagg_top
    import irqagg_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [REG_W-1:0]  src_in,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [REG_W-1:0]  wdata,
    output logic [REG_W-1:0]  rdata,
    output logic              irq_out
);
    logic [REG_W-1:0] live;
    logic [REG_W-1:0] pend;
    logic [REG_W-1:0] mask;
    logic [REG_W-1:0] pend_clr;
    logic [REG_W-1:0] mask_set;
    logic [REG_W-1:0] mask_clr;

    // Turn a write into per-bit commands for the addressed register.
    always_comb begin
        pend_clr = '0;
        mask_set = '0;
        mask_clr = '0;
        if (wr_en) begin
            unique case (addr)
                OFS_PEND: pend_clr = wdata;
                OFS_MSET: mask_set = wdata;
                OFS_MCLR: mask_clr = wdata;
                default:  ;
            endcase
        end
    end

    irqagg_sync #(.W(REG_W)) sync_i (
        .clk(clk), .rst_n(rst_n), .async_i(src_in), .sync_o(live)
    );

    irqagg_latch #(.W(REG_W)) latch_i (
        .clk(clk), .rst_n(rst_n), .level_i(live), .clr_i(pend_clr), .pend_o(pend)
    );

    irqagg_mask #(.W(REG_W)) mask_i (
        .clk(clk), .rst_n(rst_n), .set_i(mask_set), .clr_i(mask_clr), .mask_o(mask)
    );

    // Select the read data for the current address.
    always_comb begin
        unique case (addr)
            OFS_PEND: rdata = pend;
            OFS_LIVE: rdata = live;
            OFS_MSET: rdata = mask;
            default:  rdata = '0;
        endcase
    end

    assign irq_out = |(pend & mask);

    // R6
    irq_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_out && !wr_en) |=> irq_out);

    // R9
    unmapped_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (addr != OFS_PEND && addr != OFS_LIVE && addr != OFS_MSET) |-> (rdata == '0));

    // R1
    reset_quiet_chk: assert property (@(posedge clk)
        !rst_n |=> (!irq_out && pend == '0 && mask == '0));
endmodule

// File: tb/irqagg_top_tb.sv
// Directed bench for irqagg_top. Inputs are driven and outputs sampled on
// falling edges.
module irqagg_top_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 20000;

    logic        clk = 1'b0;
    logic        rst_n;
    logic [15:0] src_in;
    logic        wr_en;
    logic [7:0]  addr;
    logic [15:0] wdata;
    logic [15:0] rdata;
    logic        irq_out;

    int total = 0;
    int bad   = 0;
    bit done  = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    irqagg_top dut_i (
        .clk(clk), .rst_n(rst_n), .src_in(src_in), .wr_en(wr_en),
        .addr(addr), .wdata(wdata), .rdata(rdata), .irq_out(irq_out)
    );

    task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [15:0] d);
        @(negedge clk);
        addr = a; wdata = d; wr_en = 1'b1;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd_check(input string req, input logic [7:0] a, input logic [15:0] exp);
        @(negedge clk);
        addr = a;
        #1;
        check(req, rdata, exp);
    endtask

    task automatic settle();
        repeat (4) @(negedge clk);
    endtask

    task automatic t_reset();
        rd_check("R1 status", 8'h16, 16'h0000);
        rd_check("R1 mask", 8'h1A, 16'h0000);
        check("R1 irq", {15'd0, irq_out}, 16'h0000);
    endtask

    task automatic t_latch_disabled();
        @(negedge clk); src_in = 16'h0008;
        settle();
        rd_check("R2 pending while disabled", 8'h16, 16'h0008);
        rd_check("R7 live level", 8'h18, 16'h0008);
        check("R6 irq low when disabled", {15'd0, irq_out}, 16'h0000);
    endtask

    task automatic t_enable();
        wr(8'h1A, 16'h0008);
        rd_check("R4 mask read", 8'h1A, 16'h0008);
        check("R6 irq on enable", {15'd0, irq_out}, 16'h0001);
        wr(8'h1A, 16'h0100);
        rd_check("R4 zeros keep mask", 8'h1A, 16'h0108);
    endtask

    task automatic t_ack();
        wr(8'h16, 16'h0000);
        rd_check("R3 zero write keeps status", 8'h16, 16'h0008);
        wr(8'h16, 16'h0008);
        settle();
        rd_check("R2 held level no re-set", 8'h16, 16'h0000);
        check("R6 irq low after ack", {15'd0, irq_out}, 16'h0000);
    endtask

    task automatic t_mask_clear();
        @(negedge clk); src_in = 16'h0D08;
        settle();
        rd_check("R2 lines 8 10 11", 8'h16, 16'h0D00);
        check("R6 irq line 8", {15'd0, irq_out}, 16'h0001);
        wr(8'h1C, 16'h0100);
        rd_check("R5 mask clear", 8'h1A, 16'h0008);
        check("R5 irq low after disable", {15'd0, irq_out}, 16'h0000);
        rd_check("R7 live multi", 8'h18, 16'h0D08);
    endtask

    task automatic t_unmapped();
        wr(8'h10, 16'hFFFF);
        wr(8'h18, 16'hFFFF);
        rd_check("R9 unmapped read", 8'h10, 16'h0000);
        rd_check("R9 clear addr read", 8'h1C, 16'h0000);
        rd_check("R9 status unchanged", 8'h16, 16'h0D00);
        rd_check("R9 read no side effect", 8'h16, 16'h0D00);
        rd_check("R9 mask unchanged", 8'h1A, 16'h0008);
    endtask

    task automatic t_collision();
        @(negedge clk); src_in = 16'h0D28;
        @(negedge clk);
        @(negedge clk);
        addr = 8'h16; wdata = 16'h0020; wr_en = 1'b1;
        @(negedge clk);
        wr_en = 1'b0;
        rd_check("R8 edge beats clear", 8'h16, 16'h0D20);
    endtask

    task automatic t_init_seq();
        wr(8'h1C, 16'hFFFF);
        wr(8'h16, 16'hFFFF);
        rd_check("R10 mask cleared", 8'h1A, 16'h0000);
        rd_check("R10 nothing pending", 8'h16, 16'h0000);
        check("R10 irq low", {15'd0, irq_out}, 16'h0000);
    endtask

    task automatic t_disabled_then_enabled();
        @(negedge clk); src_in = 16'h0000;
        settle();
        @(negedge clk); src_in = 16'h8000;
        settle();
        check("R6 disabled pending no irq", {15'd0, irq_out}, 16'h0000);
        wr(8'h1A, 16'h8000);
        check("R6 irq after late enable", {15'd0, irq_out}, 16'h0001);
    endtask

    initial begin
        src_in = '0; wr_en = 1'b0; addr = '0; wdata = '0; rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_latch_disabled();
        t_enable();
        t_ack();
        t_mask_clear();
        t_unmapped();
        t_collision();
        t_init_seq();
        t_disabled_then_enabled();
        if (!done) begin
            done = 1'b1;
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (WATCHDOG) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            total++; bad++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule